// File: doc/BRIEF.md
# Diophantine divider-word solver

This block turns a signed frequency-step index into the two signed variable parts of the feedback dividers of a two-loop synthesizer. Each loop divides by a fixed modulus (N1 for the first loop, N2 for the second), and the two moduli must be coprime. The output then lands exactly `a` steps of size f_ref/(N1·N2) from its centre, with `a` anywhere from -N1·N2 to +N1·N2. The block writes the result as a pair (m1, m2), and each value is added to the fixed centre count of its loop's feedback divider.

Only the solution for a step of +1 is built in, as elaboration-time constants. A request scales that unit pair by |a|. A sequential fold engine then moves the pair along the family of solutions of the same equation, one adjustment per clock, until it is inside the legal ranges. The fold also picks a fixed, canonical member of that family. After that the sign of `a` is applied. A parameter selects one of two combining forms: the loops' contributions are added, or, for a cascade of offset stages, the second loop's contribution is subtracted.

A request is handed in with `start_i` while `ready_o` is high. The pair appears on registered outputs together with a one-cycle `done_o`. If the index is out of range, the block answers with `err_o` and leaves the previous pair untouched.

Top module: `dioph_step_solver`

## Requirements
- R1: After every successful result (done_o=1, err_o=0), the outputs satisfy an equation chosen by the FORM parameter. With SUM_FORM (encoding 0) it is m1·N2 + m2·N1 = a. With DIFF_FORM (encoding 1) it is m1·N2 − m2·N1 = a. Here a is the accepted index.
- R2: m1_o always lies in [-N1, +N1] and m2_o in [-N2, +N2]. The output widths are $clog2(N1+1)+1 and $clog2(N2+1)+1 bits, in two's complement.
- R3: Let e = m2 in SUM_FORM and e = −m2 in DIFF_FORM. For a>0 the block returns the unique solution with e in [0, N2−1]. For a<0 it returns the one with e in [−(N2−1), 0]. With N1=3, N2=2 in SUM_FORM this gives: a=1→(−1,1), a=5→(1,1), a=6→(3,0), a=−5→(−1,−1), a=−6→(−3,0) and a=3→(0,1).
- R4: An index of a=0 returns m1=0 and m2=0.
- R5: An index with |a| > N1·N2 is answered one clock after the accepting edge with done_o=1 and err_o=1. m1_o and m2_o keep their previous values.
- R6: For an in-range index, done_o rises no later than |a|+2 clock edges after the edge that accepted start_i, counting that edge.
- R7: ready_o is low from the edge that accepts an in-range index until its result is produced. A start_i seen while ready_o is low is ignored, and the pending result still belongs to the first index.
- R8: A successful result drives err_o back to 0.
- R9: Synchronous active-high reset clears m1_o, m2_o, done_o and err_o to 0, drives ready_o high, and abandons any computation in progress.
- R10: The end points a=+N1·N2 and a=−N1·N2 return (+N1, 0) and (−N1, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe, taken when ready_o is high |
| a_i | input | A_W | Signed step index, two's complement |
| ready_o | output | 1 | High when a new request can be taken |
| done_o | output | 1 | One-cycle pulse per answered request |
| err_o | output | 1 | High when the last answered index was out of range |
| m1_o | output | $clog2(N1+1)+1 | Signed variable part of the first loop's divider |
| m2_o | output | $clog2(N2+1)+1 | Signed variable part of the second loop's divider |

## Verification
The checker assumes coprime moduli and an index width A_W that can hold ±N1·N2. It also assumes that start_i is raised only when a result may be reported, which the design always allows. Its equation and sign checks use the index latched at the accepting edge, so they rely on no second request being taken while ready_o is low. The stimulus keeps within these assumptions: it uses only coprime pairs (3,2), (7,5) and (11,9) with an 8-bit index. It sweeps every index across and slightly beyond each pair's range, in both combining forms. The only requests it makes while busy are the deliberate ones that test the ignore rule.

// File: rtl/dioph_pkg.sv
package dioph_pkg;

  typedef enum logic {
    SUM_FORM  = 1'b0,
    DIFF_FORM = 1'b1
  } form_e;

  // smallest k in [0, m) with k*x = 1 (mod m); 0 when none exists
  function automatic int inv_mod(input int x, input int m);
    int r;
    r = 0;
    for (int k = m - 1; k >= 0; k--) begin
      if (((k * x) % m) == (1 % m)) r = k;
    end
    return r;
  endfunction

endpackage

// File: rtl/step_range_check.sv
module step_range_check #(
  parameter int A_W   = 8,
  parameter int NN    = 6,
  parameter int MAG_W = 3
) (
  input  logic signed [A_W-1:0]   a,
  output logic                    in_range,
  output logic                    neg,
  output logic        [MAG_W-1:0] mag
);

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  int a_int;

  always_comb begin
    a_int    = int'(a);
    in_range = (abs_i(a_int) <= NN);
    neg      = (a_int < 0);
    if (!in_range)  mag = '0;
    else if (neg)   mag = MAG_W'(-a);
    else            mag = MAG_W'(a);
  end

endmodule

// File: rtl/fold_engine.sv
module fold_engine
  import dioph_pkg::*;
#(
  parameter int    N1    = 3,
  parameter int    N2    = 2,
  parameter form_e FORM  = SUM_FORM,
  parameter int    MAG_W = 3,
  parameter int    ACC_W = 8,
  parameter int    M1_W  = 3,
  parameter int    M2_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic       [MAG_W-1:0] mag,
  input  logic                   neg,
  output logic                   busy,
  output logic                   step,
  output logic                   fin,
  output logic signed [M1_W-1:0] m1_res,
  output logic signed [M2_W-1:0] m2_res
);

  // unit solution of m1*N2 + e*N1 = 1 with e in [0, N2)
  localparam int V2 = inv_mod(N1, N2);
  localparam int U1 = (1 - V2 * N1) / N2;
  localparam logic signed [ACC_W-1:0] STEP1 = ACC_W'(N1);
  localparam logic signed [ACC_W-1:0] STEP2 = ACC_W'(N2);

  function automatic logic signed [ACC_W-1:0] scale(input logic [MAG_W-1:0] m,
                                                     input int c);
    int p;
    p = int'(m) * c;
    return ACC_W'(p);
  endfunction

  function automatic logic signed [ACC_W-1:0] flip(input logic signed [ACC_W-1:0] v,
                                                    input logic n);
    return n ? -v : v;
  endfunction

  logic                    busy_q, neg_q;
  logic signed [ACC_W-1:0] m1_acc, e2_acc;
  logic                    e2_high;
  logic signed [ACC_W-1:0] m1_sgn, e2_sgn, m2_full;

  assign e2_high = (int'(e2_acc) >= N2);
  assign busy    = busy_q;
  assign step    = busy_q && e2_high;
  assign fin     = busy_q && !e2_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      m1_acc <= '0;
      e2_acc <= '0;
    end else if (load && !busy_q) begin
      busy_q <= 1'b1;
      neg_q  <= neg;
      m1_acc <= scale(mag, U1);
      e2_acc <= scale(mag, V2);
    end else if (step) begin
      m1_acc <= m1_acc + STEP1;
      e2_acc <= e2_acc - STEP2;
    end else if (fin) begin
      busy_q <= 1'b0;
    end
  end

  assign m1_sgn = flip(m1_acc, neg_q);
  assign e2_sgn = flip(e2_acc, neg_q);

  generate
    if (FORM == DIFF_FORM) begin : g_diff
      assign m2_full = -e2_sgn;
    end else begin : g_sum
      assign m2_full = e2_sgn;
    end
  endgenerate

  assign m1_res = M1_W'(m1_sgn);
  assign m2_res = M2_W'(m2_full);

endmodule

// File: rtl/result_hold.sv
module result_hold #(
  parameter int M1_W = 3,
  parameter int M2_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fin,
  input  logic                   reject,
  input  logic signed [M1_W-1:0] m1_in,
  input  logic signed [M2_W-1:0] m2_in,
  output logic                   done_o,
  output logic                   err_o,
  output logic signed [M1_W-1:0] m1_o,
  output logic signed [M2_W-1:0] m2_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      m1_o   <= '0;
      m2_o   <= '0;
    end else begin
      done_o <= fin || reject;
      if (fin) begin
        m1_o  <= m1_in;
        m2_o  <= m2_in;
        err_o <= 1'b0;
      end else if (reject) begin
        err_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dioph_step_solver.sv
module dioph_step_solver
  import dioph_pkg::*;
#(
  parameter int    N1   = 3,
  parameter int    N2   = 2,
  parameter form_e FORM = SUM_FORM,
  parameter int    A_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic signed [A_W-1:0]         a_i,
  output logic                          ready_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic signed [$clog2(N1+1):0]  m1_o,
  output logic signed [$clog2(N2+1):0]  m2_o
);

  localparam int NN    = N1 * N2;
  localparam int MAG_W = $clog2(NN + 1);
  localparam int M1_W  = $clog2(N1 + 1) + 1;
  localparam int M2_W  = $clog2(N2 + 1) + 1;
  localparam int ACC_W = $clog2(NN * (N1 + N2) + 1) + 2;

  logic                   in_range, a_neg;
  logic       [MAG_W-1:0] a_mag;
  logic                   accept, load, reject;
  logic                   fold_busy, fold_step, fold_fin;
  logic signed [M1_W-1:0] m1_next;
  logic signed [M2_W-1:0] m2_next;

  step_range_check #(.A_W(A_W), .NN(NN), .MAG_W(MAG_W)) u_range (
    .a        (a_i),
    .in_range (in_range),
    .neg      (a_neg),
    .mag      (a_mag)
  );

  assign accept  = start_i && !fold_busy;
  assign load    = accept && in_range;
  assign reject  = accept && !in_range;
  assign ready_o = !fold_busy;

  fold_engine #(
    .N1(N1), .N2(N2), .FORM(FORM), .MAG_W(MAG_W),
    .ACC_W(ACC_W), .M1_W(M1_W), .M2_W(M2_W)
  ) u_fold (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .mag    (a_mag),
    .neg    (a_neg),
    .busy   (fold_busy),
    .step   (fold_step),
    .fin    (fold_fin),
    .m1_res (m1_next),
    .m2_res (m2_next)
  );

  result_hold #(.M1_W(M1_W), .M2_W(M2_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .fin    (fold_fin),
    .reject (reject),
    .m1_in  (m1_next),
    .m2_in  (m2_next),
    .done_o (done_o),
    .err_o  (err_o),
    .m1_o   (m1_o),
    .m2_o   (m2_o)
  );

endmodule

// File: rtl/dioph_step_solver_chk.sv
module dioph_step_solver_chk
  import dioph_pkg::*;
#(
  parameter int    N1   = 3,
  parameter int    N2   = 2,
  parameter form_e FORM = SUM_FORM,
  parameter int    A_W  = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          start_i,
  input logic signed [A_W-1:0]         a_i,
  input logic                          ready_o,
  input logic                          done_o,
  input logic                          err_o,
  input logic signed [$clog2(N1+1):0]  m1_o,
  input logic signed [$clog2(N2+1):0]  m2_o,
  input logic                          fold_step,
  input logic                          fold_fin
);

  localparam int NN = N1 * N2;

  logic signed [A_W-1:0] a_q;
  logic [15:0]           busy_cnt;
  logic                  accept_c, bad_idx;
  int                    a_abs, m1v, m2v, ev, lhs;

  assign accept_c = start_i && ready_o;

  always_comb begin
    a_abs   = (int'(a_q) < 0) ? -int'(a_q) : int'(a_q);
    bad_idx = (int'(a_i) > NN) || (int'(a_i) < -NN);
    m1v     = int'(m1_o);
    m2v     = int'(m2_o);
    ev      = (FORM == DIFF_FORM) ? -m2v : m2v;
    lhs     = m1v * N2 + ev * N1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      busy_cnt <= '0;
    end else if (accept_c) begin
      a_q      <= a_i;
      busy_cnt <= '0;
    end else if (!ready_o) begin
      busy_cnt <= busy_cnt + 16'd1;
    end
  end

  AST_EQN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (lhs == int'(a_q)));  // R1
  AST_M1_RANGE: assert property (@(posedge clk) disable iff (rst)
    (m1v >= -N1) && (m1v <= N1));  // R2
  AST_M2_RANGE: assert property (@(posedge clk) disable iff (rst)
    (m2v >= -N2) && (m2v <= N2));  // R2
  AST_SIGN_POS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o && int'(a_q) > 0) |-> (ev >= 0 && ev < N2));  // R3
  AST_SIGN_NEG: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o && int'(a_q) < 0) |-> (ev <= 0 && ev > -N2));  // R3
  AST_CENTRE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o && a_q == '0) |-> (m1v == 0 && m2v == 0));  // R4
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (accept_c && bad_idx) |=> (done_o && err_o));  // R5
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> ($stable(m1_o) && $stable(m2_o)));  // R5
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (int'(busy_cnt) <= a_abs + 1));  // R6
  AST_FIN_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    fold_fin |=> (done_o && !err_o));  // R8
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (accept_c && !bad_idx) |=> !ready_o);  // R7
  AST_STEP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    fold_step |-> (!ready_o && !done_o));  // R7

endmodule

bind dioph_step_solver dioph_step_solver_chk #(
  .N1(N1), .N2(N2), .FORM(FORM), .A_W(A_W)
) u_chk (.*);

// File: tb/dioph_step_solver_test.sv
module dioph_step_solver_test;
  import dioph_pkg::*;

  localparam int NI = 4;
  localparam int PN1 [NI] = '{3, 3, 7, 11};
  localparam int PN2 [NI] = '{2, 2, 5, 9};
  localparam int PSUB[NI] = '{0, 1, 0, 1};
  // index, expected m1, expected m2 for N1=3, N2=2, sum form
  localparam int VEC[10][3] = '{
    '{-6, -3, 0}, '{-5, -1, -1}, '{0, 0, 0}, '{1, -1, 1}, '{5, 1, 1},
    '{6, 3, 0}, '{3, 0, 1}, '{-3, 0, -1}, '{4, 2, 0}, '{-2, -1, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [7:0] a_drv = '0;

  logic rdy[NI];
  logic dn[NI];
  logic er[NI];
  logic signed [2:0] m1_0, m2_0, m1_1, m2_1;
  logic signed [3:0] m1_2, m2_2;
  logic signed [4:0] m1_3, m2_3;

  int act_m1[NI];
  int act_m2[NI];
  int prev_m1[NI];
  int prev_m2[NI];
  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dioph_step_solver #(.N1(3), .N2(2), .FORM(SUM_FORM), .A_W(8)) uut (
    .clk(clk), .rst(rst), .start_i(start), .a_i(a_drv), .ready_o(rdy[0]),
    .done_o(dn[0]), .err_o(er[0]), .m1_o(m1_0), .m2_o(m2_0));
  dioph_step_solver #(.N1(3), .N2(2), .FORM(DIFF_FORM), .A_W(8)) uut_s (
    .clk(clk), .rst(rst), .start_i(start), .a_i(a_drv), .ready_o(rdy[1]),
    .done_o(dn[1]), .err_o(er[1]), .m1_o(m1_1), .m2_o(m2_1));
  dioph_step_solver #(.N1(7), .N2(5), .FORM(SUM_FORM), .A_W(8)) uut_b (
    .clk(clk), .rst(rst), .start_i(start), .a_i(a_drv), .ready_o(rdy[2]),
    .done_o(dn[2]), .err_o(er[2]), .m1_o(m1_2), .m2_o(m2_2));
  dioph_step_solver #(.N1(11), .N2(9), .FORM(DIFF_FORM), .A_W(8)) uut_c (
    .clk(clk), .rst(rst), .start_i(start), .a_i(a_drv), .ready_o(rdy[3]),
    .done_o(dn[3]), .err_o(er[3]), .m1_o(m1_3), .m2_o(m2_3));

  always_comb begin
    act_m1[0] = int'(m1_0); act_m2[0] = int'(m2_0);
    act_m1[1] = int'(m1_1); act_m2[1] = int'(m2_1);
    act_m1[2] = int'(m1_2); act_m2[2] = int'(m2_2);
    act_m1[3] = int'(m1_3); act_m2[3] = int'(m2_3);
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cycles);
      fails = fails + 1;
      tests = tests + 1;
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // canonical pair found by searching the second variable over its signed window
  task automatic expect_pair(input int k, input int a, output int em1, output int em2,
                             output bit eerr);
    int n1, n2, s, ee;
    bit found;
    n1 = PN1[k]; n2 = PN2[k];
    em1 = 0; em2 = 0; found = 0;
    eerr = (a > n1 * n2) || (a < -n1 * n2);
    s = (a < 0) ? -1 : 1;
    if (!eerr) begin
      for (int e = 0; e < n2; e++) begin
        ee = s * e;
        if (!found && ((a - ee * n1) % n2) == 0) begin
          found = 1;
          em1 = (a - ee * n1) / n2;
          em2 = (PSUB[k] == 1) ? -ee : ee;
        end
      end
    end
  endtask

  task automatic wait_all_ready();
    for (int i = 0; i < 400; i++) begin
      if (rdy[0] && rdy[1] && rdy[2] && rdy[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic run(input int a);
    bit got[NI];
    int lat[NI];
    int em1, em2, lhs, sg, mag;
    bit eerr;
    wait_all_ready();
    for (int k = 0; k < NI; k++) begin got[k] = 0; lat[k] = 0; end
    a_drv = a[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc < 300; cyc++) begin
      for (int k = 0; k < NI; k++) begin
        if (!got[k] && dn[k]) begin got[k] = 1; lat[k] = cyc; end
      end
      if (got[0] && got[1] && got[2] && got[3]) break;
      @(negedge clk);
    end
    mag = (a < 0) ? -a : a;
    for (int k = 0; k < NI; k++) begin
      expect_pair(k, a, em1, em2, eerr);
      check(got[k], "R6 done seen", int'(got[k]), 1);
      if (eerr) begin
        check(er[k] == 1'b1, "R5 err flag", int'(er[k]), 1);
        check(lat[k] == 1, "R5 reject latency", lat[k], 1);
        check(act_m1[k] == prev_m1[k], "R5 m1 held", act_m1[k], prev_m1[k]);
        check(act_m2[k] == prev_m2[k], "R5 m2 held", act_m2[k], prev_m2[k]);
      end else begin
        sg = (PSUB[k] == 1) ? -1 : 1;
        lhs = act_m1[k] * PN2[k] + sg * act_m2[k] * PN1[k];
        check(er[k] == 1'b0, "R8 err clear", int'(er[k]), 0);
        check(lhs == a, "R1 equation", lhs, a);
        check(act_m1[k] >= -PN1[k] && act_m1[k] <= PN1[k], "R2 m1 range", act_m1[k], PN1[k]);
        check(act_m2[k] >= -PN2[k] && act_m2[k] <= PN2[k], "R2 m2 range", act_m2[k], PN2[k]);
        check(act_m1[k] == em1, "R3 m1", act_m1[k], em1);
        check(act_m2[k] == em2, "R3 m2", act_m2[k], em2);
        check(lat[k] <= mag + 2, "R6 latency", lat[k], mag + 2);
        if (a == 0) check(act_m1[k] == 0 && act_m2[k] == 0, "R4 centre", act_m1[k], 0);
        if (mag == PN1[k] * PN2[k])
          check(act_m1[k] == ((a < 0) ? -PN1[k] : PN1[k]) && act_m2[k] == 0,
                "R10 end point", act_m1[k], (a < 0) ? -PN1[k] : PN1[k]);
        prev_m1[k] = act_m1[k];
        prev_m2[k] = act_m2[k];
      end
    end
  endtask

  task automatic check_reset_state(input string tag);
    for (int k = 0; k < NI; k++) begin
      check(act_m1[k] == 0, tag, act_m1[k], 0);
      check(act_m2[k] == 0, tag, act_m2[k], 0);
      check(dn[k] == 1'b0, tag, int'(dn[k]), 0);
      check(er[k] == 1'b0, tag, int'(er[k]), 0);
      check(rdy[k] == 1'b1, tag, int'(rdy[k]), 1);
      prev_m1[k] = 0;
      prev_m2[k] = 0;
    end
  endtask

  initial begin
    int em1, em2;
    bit eerr;
    for (int i = 0; i < 4; i++) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("R9 reset state");

    // vector table for the first instance
    for (int v = 0; v < 10; v++) begin
      run(VEC[v][0]);
      check(act_m1[0] == VEC[v][1], "R3 table m1", act_m1[0], VEC[v][1]);
      check(act_m2[0] == VEC[v][2], "R3 table m2", act_m2[0], VEC[v][2]);
    end

    // full sweep across and beyond every range
    for (int a = -101; a <= 101; a++) run(a);
    run(127);
    run(-128);
    run(2);

    // R7: second request while busy is ignored
    wait_all_ready();
    a_drv = 8'sd90;
    start = 1'b1;
    @(negedge clk);
    check(rdy[3] == 1'b0, "R7 ready low while busy", int'(rdy[3]), 0);
    a_drv = 8'sd1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (dn[3]) break;
      @(negedge clk);
    end
    expect_pair(3, 90, em1, em2, eerr);
    check(dn[3] == 1'b1, "R7 done seen", int'(dn[3]), 1);
    check(act_m1[3] == em1, "R7 first index kept m1", act_m1[3], em1);
    check(act_m2[3] == em2, "R7 first index kept m2", act_m2[3], em2);
    wait_all_ready();
    @(negedge clk);
    run(5);

    // R9: reset in the middle of a fold
    wait_all_ready();
    a_drv = 8'sd90;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_reset_state("R9 mid-run reset");
    rst = 1'b0;
    @(negedge clk);
    run(-7);
    run(-1);

    summary();
    $finish;
  end

endmodule